// File: doc/BRIEF.md
# Translation Context Mode Validator

This block sits after the fetch of a device translation context and decides how that context's first-stage field and the request's process ID are to be used. It takes the context's control flags, the first-stage mode and page-number field, the context attributes, and the request's process ID with a flag that says whether the request carries one. It then returns one verdict: the first stage is bare, the first-stage field is a direct translation pointer, or the field roots a process directory that must be looked up with an effective process ID. It can also return a fault cause instead.

The checks run in a fixed order. A bare first-stage mode ends validation at once. Next come process-ID blocking and the mode-range check for the direct case. For the directory case, default process-ID handling comes before the directory mode-range check. A directory verdict issues a one-cycle lookup request carrying the effective ID and the directory root. An external agent answers with the fetched directory entry, and the final result then carries that entry's mode, page number and attributes. An optional register stage between the decision logic and the sequencer is chosen by parameter.

Top module: `ctx_mode_validator`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `pd_req` are 0.
- R2: A request whose first-stage mode is 0 (bare) completes with kind 0 (bare), cause 0, mode 0 and page number 0, whatever the flags and process ID are.
- R3: With the directory flag clear, a non-bare mode and a process ID present, the request completes with kind 3 (fault) and cause 260 (transaction type blocked). This check takes precedence over the mode-range check of R4.
- R4: With the directory flag clear, no process ID and a non-bare mode, a mode above 10 completes with kind 3 and cause 258 (context invalid). Modes from 1 to 10 complete with kind 1 (direct) and carry the context's mode, page number and attributes.
- R5: With the directory flag set, no process ID and the default-ID enable clear, the request completes as kind 0 (bare) with cause 0, even when the mode is out of range.
- R6: With the directory flag set, no process ID and the default-ID enable set, the directory lookup uses process ID 0.
- R7: With the directory flag set and R5 not applying, a mode above 3 completes with kind 3 and cause 258.
- R8: A valid directory verdict raises `pd_req` for exactly one cycle with the effective ID, mode and page number. The entry returned on `pde_valid` completes the request as kind 2, carrying the entry's mode, page number and attributes and the effective ID.
- R9: On every `done`, `res_cause` is nonzero exactly when `res_kind` is 3. Fault results carry zero in all other fields.
- R10: Each accepted request gives exactly one one-cycle `done`. `req_ready` is low from acceptance until completion, so requests presented meanwhile are ignored.
- R11: `pde_valid` while no lookup is pending has no effect: no `done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| ctx_pdtv | input | 1 | Context flag: first-stage field roots a process directory |
| ctx_dpe | input | 1 | Context flag: default process ID 0 enabled |
| ctx_fs_mode | input | MODE_W | First-stage mode field |
| ctx_fs_ppn | input | PPN_W | First-stage page number field |
| ctx_attr | input | ATTR_W | Context translation attributes |
| req_no_pid | input | 1 | Request carries no process ID |
| req_pid | input | PID_W | Request process ID |
| pd_req | output | 1 | One-cycle directory lookup request |
| pd_pid | output | PID_W | Effective process ID for the lookup |
| pd_mode | output | MODE_W | Directory mode |
| pd_ppn | output | PPN_W | Directory root page number |
| pde_valid | input | 1 | Directory entry returned |
| pde_fs_mode | input | MODE_W | Entry first-stage mode |
| pde_fs_ppn | input | PPN_W | Entry first-stage page number |
| pde_attr | input | ATTR_W | Entry attributes |
| done | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 bare, 1 direct, 2 directory, 3 fault |
| res_cause | output | CAUSE_W | Fault cause, zero on success |
| res_pid | output | PID_W | Effective process ID (directory results) |
| res_fs_mode | output | MODE_W | Resulting first-stage mode |
| res_fs_ppn | output | PPN_W | Resulting first-stage page number |
| res_attr | output | ATTR_W | Resulting attributes |

## Verification
The assertions check on every cycle that a done strobe lasts a single cycle, that a lookup request is a single pulse, and that a returned entry always completes a pending lookup. They also check that a fault is flagged exactly when the cause is nonzero and that idle cycles without a request produce no result. In the unstaged variant, they tie bare exits, blocking and forced-bare outcomes and default ID 0 to the request one cycle earlier. Only the bench scenarios show the mode-range boundaries (10/11 direct, 3/4 directory) and the ordering between blocking and range faults. The same holds for the exact fields carried from a returned entry and for requests or stray entries presented while the block is busy or idle being ignored.

// File: rtl/cmv_pkg.sv
package cmv_pkg;
   localparam int CAUSE_W = 12;
   localparam logic [CAUSE_W-1:0] CAUSE_NONE        = 12'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_CTX_INVALID = 12'd258;
   localparam logic [CAUSE_W-1:0] CAUSE_BLOCKED     = 12'd260;

   typedef enum logic [1:0] {
      K_BARE   = 2'd0,
      K_DIRECT = 2'd1,
      K_PDIR   = 2'd2,
      K_FAULT  = 2'd3
   } kind_e;

   typedef struct packed {
      kind_e               kind;
      logic [CAUSE_W-1:0]  cause;
   } verdict_t;
endpackage

// File: rtl/cmv_decide.sv
module cmv_decide
   import cmv_pkg::*;
#(
   parameter int MODE_W        = 4,
   parameter int PPN_W         = 44,
   parameter int PID_W         = 20,
   parameter int ATTR_W        = 32,
   parameter int MAX_DIRECT_MD = 10,
   parameter int MAX_PDIR_MD   = 3
) (
   input  logic              pdtv,
   input  logic              dpe,
   input  logic [MODE_W-1:0] mode,
   input  logic [PPN_W-1:0]  ppn,
   input  logic [ATTR_W-1:0] attr,
   input  logic              no_pid,
   input  logic [PID_W-1:0]  pid,
   output verdict_t          verdict,
   output logic [PID_W-1:0]  o_pid,
   output logic [MODE_W-1:0] o_mode,
   output logic [PPN_W-1:0]  o_ppn,
   output logic [ATTR_W-1:0] o_attr
);
   localparam logic [MODE_W-1:0] LIM_DIRECT = MODE_W'(MAX_DIRECT_MD);
   localparam logic [MODE_W-1:0] LIM_PDIR   = MODE_W'(MAX_PDIR_MD);

   logic is_bare;
   assign is_bare = (mode == '0);

   always_comb begin
      verdict.kind  = K_BARE;
      verdict.cause = CAUSE_NONE;
      o_pid  = '0;
      o_mode = '0;
      o_ppn  = '0;
      o_attr = attr;
      if (is_bare) begin
         verdict.kind = K_BARE;
      end else if (!pdtv) begin
         if (!no_pid) begin
            verdict.kind  = K_FAULT;
            verdict.cause = CAUSE_BLOCKED;
            o_attr        = '0;
         end else if (mode > LIM_DIRECT) begin
            verdict.kind  = K_FAULT;
            verdict.cause = CAUSE_CTX_INVALID;
            o_attr        = '0;
         end else begin
            verdict.kind = K_DIRECT;
            o_mode       = mode;
            o_ppn        = ppn;
         end
      end else if (no_pid && !dpe) begin
         verdict.kind = K_BARE;
      end else if (mode > LIM_PDIR) begin
         verdict.kind  = K_FAULT;
         verdict.cause = CAUSE_CTX_INVALID;
         o_attr        = '0;
      end else begin
         verdict.kind = K_PDIR;
         o_pid        = no_pid ? '0 : pid;
         o_mode       = mode;
         o_ppn        = ppn;
      end
   end
endmodule

// File: rtl/cmv_ctrl.sv
module cmv_ctrl
   import cmv_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int PPN_W  = 44,
   parameter int PID_W  = 20,
   parameter int ATTR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_valid,
   input  verdict_t           verdict,
   input  logic [PID_W-1:0]   d_pid,
   input  logic [MODE_W-1:0]  d_mode,
   input  logic [PPN_W-1:0]   d_ppn,
   input  logic [ATTR_W-1:0]  d_attr,
   input  logic               pde_valid,
   input  logic [MODE_W-1:0]  pde_fs_mode,
   input  logic [PPN_W-1:0]   pde_fs_ppn,
   input  logic [ATTR_W-1:0]  pde_attr,
   output logic               idle,
   output logic               pd_req,
   output logic [PID_W-1:0]   pd_pid,
   output logic [MODE_W-1:0]  pd_mode,
   output logic [PPN_W-1:0]   pd_ppn,
   output logic               done,
   output logic [1:0]         res_kind,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [PID_W-1:0]   res_pid,
   output logic [MODE_W-1:0]  res_fs_mode,
   output logic [PPN_W-1:0]   res_fs_ppn,
   output logic [ATTR_W-1:0]  res_attr
);
   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;
   st_e state;

   assign idle = (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         pd_req      <= 1'b0;
         pd_pid      <= '0;
         pd_mode     <= '0;
         pd_ppn      <= '0;
         done        <= 1'b0;
         res_kind    <= '0;
         res_cause   <= '0;
         res_pid     <= '0;
         res_fs_mode <= '0;
         res_fs_ppn  <= '0;
         res_attr    <= '0;
      end else begin
         done   <= 1'b0;
         pd_req <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (dec_valid) begin
                  if (verdict.kind == K_PDIR) begin
                     state   <= ST_WAIT;
                     pd_req  <= 1'b1;
                     pd_pid  <= d_pid;
                     pd_mode <= d_mode;
                     pd_ppn  <= d_ppn;
                  end else begin
                     done        <= 1'b1;
                     res_kind    <= verdict.kind;
                     res_cause   <= verdict.cause;
                     res_pid     <= d_pid;
                     res_fs_mode <= d_mode;
                     res_fs_ppn  <= d_ppn;
                     res_attr    <= d_attr;
                  end
               end
            end
            ST_WAIT: begin
               if (pde_valid) begin
                  state       <= ST_IDLE;
                  done        <= 1'b1;
                  res_kind    <= K_PDIR;
                  res_cause   <= CAUSE_NONE;
                  res_pid     <= pd_pid;
                  res_fs_mode <= pde_fs_mode;
                  res_fs_ppn  <= pde_fs_ppn;
                  res_attr    <= pde_attr;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_pd_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |=> !pd_req);
   a_r8_entry_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && pde_valid) |=> (done && res_kind == K_PDIR && res_cause == '0));
   a_r9_cause_iff_fault: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((res_kind == K_FAULT) == (res_cause != '0)));
   a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !dec_valid) |=> !done);
   a_r10_wait_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !pde_valid) |=> !done);
endmodule

// File: rtl/ctx_mode_validator.sv
module ctx_mode_validator
   import cmv_pkg::*;
#(
   parameter int MODE_W        = 4,
   parameter int PPN_W         = 44,
   parameter int PID_W         = 20,
   parameter int ATTR_W        = 32,
   parameter int MAX_DIRECT_MD = 10,
   parameter int MAX_PDIR_MD   = 3,
   parameter bit STAGE_DECIDE  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               ctx_pdtv,
   input  logic               ctx_dpe,
   input  logic [MODE_W-1:0]  ctx_fs_mode,
   input  logic [PPN_W-1:0]   ctx_fs_ppn,
   input  logic [ATTR_W-1:0]  ctx_attr,
   input  logic               req_no_pid,
   input  logic [PID_W-1:0]   req_pid,
   output logic               pd_req,
   output logic [PID_W-1:0]   pd_pid,
   output logic [MODE_W-1:0]  pd_mode,
   output logic [PPN_W-1:0]   pd_ppn,
   input  logic               pde_valid,
   input  logic [MODE_W-1:0]  pde_fs_mode,
   input  logic [PPN_W-1:0]   pde_fs_ppn,
   input  logic [ATTR_W-1:0]  pde_attr,
   output logic               done,
   output logic [1:0]         res_kind,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [PID_W-1:0]   res_pid,
   output logic [MODE_W-1:0]  res_fs_mode,
   output logic [PPN_W-1:0]   res_fs_ppn,
   output logic [ATTR_W-1:0]  res_attr
);
   localparam int MODE_SPAN = 1 << MODE_W;

   if (MODE_W < 2 || MODE_W > 8) begin : g_bad_mode_w
      $error("MODE_W out of range");
   end
   if (MAX_DIRECT_MD >= MODE_SPAN || MAX_PDIR_MD >= MODE_SPAN) begin : g_bad_limit
      $error("mode limits do not fit MODE_W");
   end
   if (PID_W < 1 || PPN_W < 1 || ATTR_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic              ctrl_idle, stage_busy, req_fire, dec_valid;
   verdict_t          c_verdict, v_verdict;
   logic [PID_W-1:0]  c_pid,  v_pid;
   logic [MODE_W-1:0] c_mode, v_mode;
   logic [PPN_W-1:0]  c_ppn,  v_ppn;
   logic [ATTR_W-1:0] c_attr, v_attr;

   assign req_ready = ctrl_idle && !stage_busy;
   assign req_fire  = req_valid && req_ready;

   cmv_decide #(
      .MODE_W(MODE_W), .PPN_W(PPN_W), .PID_W(PID_W), .ATTR_W(ATTR_W),
      .MAX_DIRECT_MD(MAX_DIRECT_MD), .MAX_PDIR_MD(MAX_PDIR_MD)
   ) u_decide (
      .pdtv(ctx_pdtv), .dpe(ctx_dpe), .mode(ctx_fs_mode), .ppn(ctx_fs_ppn),
      .attr(ctx_attr), .no_pid(req_no_pid), .pid(req_pid),
      .verdict(c_verdict), .o_pid(c_pid), .o_mode(c_mode), .o_ppn(c_ppn),
      .o_attr(c_attr)
   );

   if (STAGE_DECIDE) begin : g_staged
      logic              s_valid;
      verdict_t          s_verdict;
      logic [PID_W-1:0]  s_pid;
      logic [MODE_W-1:0] s_mode;
      logic [PPN_W-1:0]  s_ppn;
      logic [ATTR_W-1:0] s_attr;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_valid   <= 1'b0;
            s_verdict <= '0;
            s_pid     <= '0;
            s_mode    <= '0;
            s_ppn     <= '0;
            s_attr    <= '0;
         end else begin
            s_valid <= req_fire;
            if (req_fire) begin
               s_verdict <= c_verdict;
               s_pid     <= c_pid;
               s_mode    <= c_mode;
               s_ppn     <= c_ppn;
               s_attr    <= c_attr;
            end
         end
      end
      assign stage_busy = s_valid;
      assign dec_valid  = s_valid;
      assign v_verdict  = s_verdict;
      assign v_pid      = s_pid;
      assign v_mode     = s_mode;
      assign v_ppn      = s_ppn;
      assign v_attr     = s_attr;
   end else begin : g_direct
      assign stage_busy = 1'b0;
      assign dec_valid  = req_fire;
      assign v_verdict  = c_verdict;
      assign v_pid      = c_pid;
      assign v_mode     = c_mode;
      assign v_ppn      = c_ppn;
      assign v_attr     = c_attr;

      a_r2_bare_exit: assert property (@(posedge clk) disable iff (!rst_n)
         (req_fire && ctx_fs_mode == '0) |=>
            (done && res_kind == K_BARE && res_cause == '0 && res_fs_mode == '0));
      a_r3_blocked: assert property (@(posedge clk) disable iff (!rst_n)
         (req_fire && ctx_fs_mode != '0 && !ctx_pdtv && !req_no_pid) |=>
            (done && res_kind == K_FAULT && res_cause == CAUSE_BLOCKED));
      a_r5_forced_bare: assert property (@(posedge clk) disable iff (!rst_n)
         (req_fire && ctx_fs_mode != '0 && ctx_pdtv && req_no_pid && !ctx_dpe) |=>
            (done && res_kind == K_BARE && res_fs_mode == '0));
      a_r6_default_pid: assert property (@(posedge clk) disable iff (!rst_n)
         (req_fire && ctx_fs_mode != '0 && ctx_pdtv && req_no_pid && ctx_dpe &&
          ctx_fs_mode <= MODE_W'(MAX_PDIR_MD)) |=> (pd_req && pd_pid == '0));
   end

   cmv_ctrl #(
      .MODE_W(MODE_W), .PPN_W(PPN_W), .PID_W(PID_W), .ATTR_W(ATTR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .verdict(v_verdict),
      .d_pid(v_pid), .d_mode(v_mode), .d_ppn(v_ppn), .d_attr(v_attr),
      .pde_valid(pde_valid), .pde_fs_mode(pde_fs_mode), .pde_fs_ppn(pde_fs_ppn),
      .pde_attr(pde_attr), .idle(ctrl_idle), .pd_req(pd_req), .pd_pid(pd_pid),
      .pd_mode(pd_mode), .pd_ppn(pd_ppn), .done(done), .res_kind(res_kind),
      .res_cause(res_cause), .res_pid(res_pid), .res_fs_mode(res_fs_mode),
      .res_fs_ppn(res_fs_ppn), .res_attr(res_attr)
   );
endmodule

// File: tb/ctx_mode_validator_test.sv
module ctx_mode_validator_test;
   localparam int MW = 4, PW = 44, IW = 20, AW = 32, CW = 12;

   typedef struct {
      string       tag;
      logic [1:0]  kind;
      logic [CW-1:0] cause;
      logic [IW-1:0] pid;
      logic [MW-1:0] mode;
      logic [PW-1:0] ppn;
      logic [AW-1:0] attr;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, ctx_pdtv = 0, ctx_dpe = 0, req_no_pid = 1;
   logic [MW-1:0] ctx_fs_mode = '0;
   logic [PW-1:0] ctx_fs_ppn = '0;
   logic [AW-1:0] ctx_attr = '0;
   logic [IW-1:0] req_pid = '0;
   logic pde_valid = 0;
   logic [MW-1:0] pde_fs_mode = '0;
   logic [PW-1:0] pde_fs_ppn = '0;
   logic [AW-1:0] pde_attr = '0;
   logic req_ready, pd_req, done;
   logic [IW-1:0] pd_pid, res_pid;
   logic [MW-1:0] pd_mode, res_fs_mode;
   logic [PW-1:0] pd_ppn, res_fs_ppn;
   logic [1:0] res_kind;
   logic [CW-1:0] res_cause;
   logic [AW-1:0] res_attr;

   int vectors = 0, miscompares = 0;
   exp_t q[$];
   logic [IW-1:0] exp_pd_pid;
   logic [MW-1:0] exp_pd_mode;
   logic [PW-1:0] exp_pd_ppn;
   string exp_pd_tag;

   always #10 clk = ~clk;

   ctx_mode_validator uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .ctx_pdtv(ctx_pdtv), .ctx_dpe(ctx_dpe), .ctx_fs_mode(ctx_fs_mode),
      .ctx_fs_ppn(ctx_fs_ppn), .ctx_attr(ctx_attr), .req_no_pid(req_no_pid),
      .req_pid(req_pid), .pd_req(pd_req), .pd_pid(pd_pid), .pd_mode(pd_mode),
      .pd_ppn(pd_ppn), .pde_valid(pde_valid), .pde_fs_mode(pde_fs_mode),
      .pde_fs_ppn(pde_fs_ppn), .pde_attr(pde_attr), .done(done),
      .res_kind(res_kind), .res_cause(res_cause), .res_pid(res_pid),
      .res_fs_mode(res_fs_mode), .res_fs_ppn(res_fs_ppn), .res_attr(res_attr)
   );

   function automatic logic [MW-1:0] ent_mode(logic [IW-1:0] p);
      return 4'd8 + {2'b00, p[1:0]};
   endfunction
   function automatic logic [PW-1:0] ent_ppn(logic [IW-1:0] p);
      return {p, 24'hABCDEF};
   endfunction
   function automatic logic [AW-1:0] ent_attr(logic [IW-1:0] p);
      return {12'h5A5, p};
   endfunction

   // monitor: pops expected results as done strobes appear
   initial forever begin
      @(negedge clk);
      if (rst_n && done) begin
         vectors++;
         if (q.size() == 0) begin
            miscompares++;
            $display("FAIL R10 unexpected done: got kind=%0d cause=%0d, expected no result",
                     res_kind, res_cause);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (res_kind !== e.kind || res_cause !== e.cause || res_pid !== e.pid ||
                res_fs_mode !== e.mode || res_fs_ppn !== e.ppn || res_attr !== e.attr) begin
               miscompares++;
               $display("FAIL %s got kind=%0d cause=%0d pid=%h mode=%0d ppn=%h attr=%h expected kind=%0d cause=%0d pid=%h mode=%0d ppn=%h attr=%h",
                  e.tag, res_kind, res_cause, res_pid, res_fs_mode, res_fs_ppn, res_attr,
                  e.kind, e.cause, e.pid, e.mode, e.ppn, e.attr);
            end
         end
      end
   end

   // directory responder: checks the lookup request, answers after a delay
   initial forever begin
      @(negedge clk);
      if (rst_n && pd_req) begin
         logic [IW-1:0] p;
         p = pd_pid;
         vectors++;
         if (pd_pid !== exp_pd_pid || pd_mode !== exp_pd_mode || pd_ppn !== exp_pd_ppn) begin
            miscompares++;
            $display("FAIL %s lookup got pid=%h mode=%0d ppn=%h expected pid=%h mode=%0d ppn=%h",
                     exp_pd_tag, pd_pid, pd_mode, pd_ppn, exp_pd_pid, exp_pd_mode, exp_pd_ppn);
         end
         repeat (3) @(negedge clk);
         pde_valid   = 1'b1;
         pde_fs_mode = ent_mode(p);
         pde_fs_ppn  = ent_ppn(p);
         pde_attr    = ent_attr(p);
         @(negedge clk);
         pde_valid = 1'b0;
      end
   end

   task automatic apply(input string tag, input bit pdtv, input bit dpe,
                        input logic [MW-1:0] mode, input logic [PW-1:0] ppn,
                        input logic [AW-1:0] attr, input bit no_pid,
                        input logic [IW-1:0] pid, input bit junk);
      exp_t e;
      logic [IW-1:0] eff;
      e.tag = tag; e.kind = 2'd0; e.cause = '0; e.pid = '0;
      e.mode = '0; e.ppn = '0; e.attr = attr;
      if (mode == 0) begin
         e.kind = 2'd0;
      end else if (!pdtv) begin
         if (!no_pid) begin
            e.kind = 2'd3; e.cause = 12'd260; e.attr = '0;
         end else if (mode > 4'd10) begin
            e.kind = 2'd3; e.cause = 12'd258; e.attr = '0;
         end else begin
            e.kind = 2'd1; e.mode = mode; e.ppn = ppn;
         end
      end else if (no_pid && !dpe) begin
         e.kind = 2'd0;
      end else if (mode > 4'd3) begin
         e.kind = 2'd3; e.cause = 12'd258; e.attr = '0;
      end else begin
         eff = no_pid ? '0 : pid;
         e.kind = 2'd2; e.pid = eff; e.mode = ent_mode(eff);
         e.ppn = ent_ppn(eff); e.attr = ent_attr(eff);
         exp_pd_pid = eff; exp_pd_mode = mode; exp_pd_ppn = ppn; exp_pd_tag = tag;
      end
      q.push_back(e);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      ctx_pdtv = pdtv; ctx_dpe = dpe; ctx_fs_mode = mode; ctx_fs_ppn = ppn;
      ctx_attr = attr; req_no_pid = no_pid; req_pid = pid; req_valid = 1'b1;
      @(negedge clk);
      if (junk) begin
         ctx_pdtv = 1'b0; ctx_fs_mode = '0; ctx_attr = 32'hDEAD0000;
         repeat (2) @(negedge clk);
      end
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      vectors++;
      if (req_ready !== 1'b1 || done !== 1'b0 || pd_req !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 reset state got ready=%b done=%b pd_req=%b expected 1 0 0",
                  req_ready, done, pd_req);
      end
      apply("R2 bare with pid",        0, 0, 4'd0,  44'h123, 32'h11, 0, 20'h7, 0);
      apply("R2 bare dir flag",        1, 1, 4'd0,  44'h456, 32'h22, 1, 20'h0, 0);
      apply("R3 blocked",              0, 0, 4'd8,  44'h789, 32'h33, 0, 20'h5, 0);
      apply("R3 blocked over range",   0, 0, 4'd12, 44'h789, 32'h33, 0, 20'h5, 0);
      apply("R4 direct mode 9",        0, 1, 4'd9,  44'hABC, 32'h44, 1, 20'h0, 0);
      apply("R4 direct boundary 10",   0, 0, 4'd10, 44'hFFFFFFFFFFF, 32'h55, 1, 20'h0, 0);
      apply("R4 invalid 11",           0, 0, 4'd11, 44'h1, 32'h66, 1, 20'h0, 0);
      apply("R4 invalid 15",           0, 0, 4'd15, 44'h1, 32'h66, 1, 20'h0, 0);
      apply("R5 forced bare",          1, 0, 4'd2,  44'h999, 32'h77, 1, 20'h0, 0);
      apply("R5 forced bare over range", 1, 0, 4'd9, 44'h999, 32'h78, 1, 20'h0, 0);
      apply("R6 default pid 0",        1, 1, 4'd1,  44'h2000, 32'h88, 1, 20'h0, 0);
      apply("R8 lookup mode 3",        1, 0, 4'd3,  44'h3000, 32'h99, 0, 20'h1234B, 0);
      apply("R7 invalid dir mode 4",   1, 0, 4'd4,  44'h3000, 32'h99, 0, 20'h1234B, 0);
      apply("R7 invalid with default", 1, 1, 4'd7,  44'h3000, 32'h99, 1, 20'h0, 0);
      apply("R10 busy ignores request", 1, 1, 4'd2, 44'h4000, 32'hAA, 0, 20'hFFFFF, 1);
      // R11: stray directory entry while idle
      @(negedge clk);
      pde_valid = 1'b1; pde_fs_mode = 4'd9; pde_fs_ppn = 44'h5; pde_attr = 32'h5;
      @(negedge clk);
      pde_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         vectors++;
         if (done !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 stray entry got done=%b expected 0", done);
         end
         @(negedge clk);
      end
      apply("R9 fault after stray",    0, 0, 4'd13, 44'h6, 32'hBB, 1, 20'h0, 0);
      apply("R8 lookup after stray",   1, 0, 4'd1,  44'h7000, 32'hCC, 0, 20'h00042, 0);
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule